// File: doc/BRIEF.md
# TCP Offload Register Control Sequencer

This block drives the register port of a TCP offload engine through a fixed bring-up and transfer sequence. A push button, passed through a synchronizer and a debounce counter, starts the run. The block then loads the engine's network identity (MAC address, local and remote IP address, port numbers and an open-mode word) through single-cycle register writes. Next it releases the engine from reset and polls the busy flag until initialization has finished.

Once initialized, the block acts as a passive server. It waits for a remote client to raise the connection-on status. If the mode input is low, it sends data: it programs the total length and the packet length, issues the send command, waits for the engine to go idle, then commands an active close and waits again. If the mode input is high, it receives data: it issues no writes and waits for the remote side to close, then waits for the engine to go idle. Both paths come back to waiting for the next connection. The parameters are not loaded again and the engine reset is not released again.

Top module: `toe_reg_sequencer`

## Requirements
- R1: While reset is high and after it falls, `reg_wr_en` is 0, `reg_addr` is 0 and `reg_wr_data` is 0. No write occurs until a start press is accepted.
- R2: A raw button level is accepted only after it has been sampled high for `DEB_CYCLES` consecutive cycles past a two-flop synchronizer. The first write appears exactly `DEB_CYCLES+3` rising edges after the button is first high. A shorter press has no effect, and a held button starts only one sequence.
- R3: The load phase consists of 8 writes on consecutive cycles, in this order: address 0 = 1 (hold engine in reset), 4 = 0x02030405 (MAC low), 5 = 0x00000001 (MAC high), 6 = 0xC0A80B2A (local IP), 7 = 0xC0A80B19 (remote IP), 8 = 0x00000FA0 (local port 4000), 9 = `DST_PORT` (default 4000), 10 = 0 (passive open).
- R4: On the cycle after the last load write, address 0 (engine reset) is written with 0.
- R5: A busy poll takes two cycles with `reg_addr` = 1 (command register) and no write. The read data is sampled at the end of the second cycle, one cycle after the read was issued. If bit 0 is 1, the pair repeats. If it is 0, the next action starts on the following cycle. Bits 31..1 of the read data are zero.
- R6: After initialization, no write occurs while `conn_on` is 0, and button presses are ignored.
- R7: When `conn_on` is 1 and `mode_sel` is 0, the next three cycles write address 2 = `TOTAL_LEN`, address 3 = `PKT_LEN`, and address 1 = 0 (send). A busy poll follows.
- R8: On the cycle after the send poll reads 0, address 1 is written with 3 (active close). A busy poll follows.
- R9: After the close poll reads 0, the block waits for a connection again with no writes.
- R10: When `conn_on` is 1 and `mode_sel` is 1, no write occurs while `conn_on` stays 1. On the cycle after `conn_on` falls, a busy poll starts, and the block then waits for a connection.
- R11: A later connection starts a new transfer directly, without reloading parameters or writing the engine reset again.
- R12: `mode_sel` is used only in the cycle in which the open is detected. Changing it during a receive has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_btn | input | 1 | Raw start button level |
| mode_sel | input | 1 | 0 = transmit, 1 = receive |
| conn_on | input | 1 | Engine connection-on status |
| reg_rd_data | input | 32 | Register read data, one cycle after the address |
| reg_addr | output | 4 | Register address |
| reg_wr_en | output | 1 | Single-cycle write strobe |
| reg_wr_data | output | 32 | Register write data |

## Verification
Every output is a decode of the current state, so each result is due exactly one rising edge after the input or sampled read data that causes it. A write therefore appears on the cycle after `conn_on` rises, and on the cycle after a poll samples a clear busy bit. The first load write lands `DEB_CYCLES+3` edges after the button rises. The bench holds a behavioural engine model and a script of expected cycles, and compares the outputs once per clock at the falling edge. It also updates the modelled busy flag and read data at that same falling edge, so the sampling edge always sees the value the script predicts.

// File: rtl/toe_seq_pkg.sv
package toe_seq_pkg;

    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 32;
    localparam int NUM_PARAMS = 8;
    localparam int IDX_W      = $clog2(NUM_PARAMS);

    // register map of the engine port
    localparam logic [ADDR_W-1:0] A_RST    = 4'd0;
    localparam logic [ADDR_W-1:0] A_CMD    = 4'd1;
    localparam logic [ADDR_W-1:0] A_TDL    = 4'd2;
    localparam logic [ADDR_W-1:0] A_PKL    = 4'd3;
    localparam logic [ADDR_W-1:0] A_MAC_LO = 4'd4;
    localparam logic [ADDR_W-1:0] A_MAC_HI = 4'd5;
    localparam logic [ADDR_W-1:0] A_LIP    = 4'd6;
    localparam logic [ADDR_W-1:0] A_RIP    = 4'd7;
    localparam logic [ADDR_W-1:0] A_LPORT  = 4'd8;
    localparam logic [ADDR_W-1:0] A_RPORT  = 4'd9;
    localparam logic [ADDR_W-1:0] A_OMODE  = 4'd10;

    localparam logic [DATA_W-1:0] CMD_SEND  = 32'd0;
    localparam logic [DATA_W-1:0] CMD_CLOSE = 32'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PARAM,
        ST_CLR_RST,
        ST_POLL_REQ,
        ST_POLL_CHK,
        ST_WT_OPEN,
        ST_TX_TDL,
        ST_TX_PKL,
        ST_TX_SEND,
        ST_TX_CLOSE,
        ST_WT_CLOSE
    } seq_st_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_acc_t;

    function automatic reg_acc_t mk_acc(input logic en,
                                        input logic [ADDR_W-1:0] addr,
                                        input logic [DATA_W-1:0] data);
        reg_acc_t r;
        r.en   = en;
        r.addr = addr;
        r.data = data;
        return r;
    endfunction

endpackage

// File: rtl/toe_seq_debounce.sv
module toe_seq_debounce #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic press_pulse
);
    localparam int CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] LIM = CW'(DEB_CYCLES - 1);

    logic          s1, s2, stable, stable_q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1       <= 1'b0;
            s2       <= 1'b0;
            stable   <= 1'b0;
            stable_q <= 1'b0;
            cnt      <= '0;
        end else begin
            s1       <= btn_raw;
            s2       <= s1;
            stable_q <= stable;
            if (s2 == stable) begin
                cnt <= '0;
            end else if (cnt == LIM) begin
                stable <= s2;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign press_pulse = stable & ~stable_q;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        press_pulse |=> !press_pulse); // R2

endmodule

// File: rtl/toe_seq_param_rom.sv
module toe_seq_param_rom
    import toe_seq_pkg::*;
#(
    parameter logic [15:0] DST_PORT = 16'd4000
) (
    input  logic [IDX_W-1:0] idx,
    output reg_acc_t         acc
);
    always_comb begin
        unique case (idx)
            3'd0: acc = mk_acc(1'b1, A_RST,    32'd1);
            3'd1: acc = mk_acc(1'b1, A_MAC_LO, 32'h0203_0405);
            3'd2: acc = mk_acc(1'b1, A_MAC_HI, 32'h0000_0001);
            3'd3: acc = mk_acc(1'b1, A_LIP,    {8'd192, 8'd168, 8'd11, 8'd42});
            3'd4: acc = mk_acc(1'b1, A_RIP,    {8'd192, 8'd168, 8'd11, 8'd25});
            3'd5: acc = mk_acc(1'b1, A_LPORT,  32'd4000);
            3'd6: acc = mk_acc(1'b1, A_RPORT,  {16'd0, DST_PORT});
            default: acc = mk_acc(1'b1, A_OMODE, 32'd0);
        endcase
    end
endmodule

// File: rtl/toe_seq_bus_drive.sv
module toe_seq_bus_drive
    import toe_seq_pkg::*;
#(
    parameter logic [DATA_W-1:0] TOTAL_LEN = 32'd23360,
    parameter logic [DATA_W-1:0] PKT_LEN   = 32'd1460
) (
    input  seq_st_e  st,
    input  reg_acc_t rom_acc,
    output reg_acc_t bus
);
    always_comb begin
        unique case (st)
            ST_PARAM:    bus = rom_acc;
            ST_CLR_RST:  bus = mk_acc(1'b1, A_RST, 32'd0);
            ST_POLL_REQ,
            ST_POLL_CHK: bus = mk_acc(1'b0, A_CMD, 32'd0);
            ST_TX_TDL:   bus = mk_acc(1'b1, A_TDL, TOTAL_LEN);
            ST_TX_PKL:   bus = mk_acc(1'b1, A_PKL, PKT_LEN);
            ST_TX_SEND:  bus = mk_acc(1'b1, A_CMD, CMD_SEND);
            ST_TX_CLOSE: bus = mk_acc(1'b1, A_CMD, CMD_CLOSE);
            default:     bus = mk_acc(1'b0, A_RST, 32'd0);
        endcase
    end
endmodule

// File: rtl/toe_reg_sequencer.sv
module toe_reg_sequencer
    import toe_seq_pkg::*;
#(
    parameter int          DEB_CYCLES = 16,
    parameter logic [31:0] TOTAL_LEN  = 32'd23360,
    parameter logic [31:0] PKT_LEN    = 32'd1460,
    parameter logic [15:0] DST_PORT   = 16'd4000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_btn,
    input  logic        mode_sel,
    input  logic        conn_on,
    input  logic [31:0] reg_rd_data,
    output logic [3:0]  reg_addr,
    output logic        reg_wr_en,
    output logic [31:0] reg_wr_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PARAMS - 1);

    seq_st_e          st, ret_st;
    logic [IDX_W-1:0] idx;
    logic             start_pulse;
    logic             busy;
    reg_acc_t         rom_acc, bus;

    assign busy = reg_rd_data[0];

    toe_seq_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk(clk), .rst(rst), .btn_raw(start_btn), .press_pulse(start_pulse)
    );

    toe_seq_param_rom #(.DST_PORT(DST_PORT)) u_rom (
        .idx(idx), .acc(rom_acc)
    );

    toe_seq_bus_drive #(.TOTAL_LEN(TOTAL_LEN), .PKT_LEN(PKT_LEN)) u_bus (
        .st(st), .rom_acc(rom_acc), .bus(bus)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            ret_st <= ST_WT_OPEN;
            idx    <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start_pulse) begin
                    st  <= ST_PARAM;
                    idx <= '0;
                end
                ST_PARAM: begin
                    idx <= idx + 1'b1;
                    if (idx == LAST_IDX) st <= ST_CLR_RST;
                end
                ST_CLR_RST: begin
                    st     <= ST_POLL_REQ;
                    ret_st <= ST_WT_OPEN;
                end
                ST_POLL_REQ: st <= ST_POLL_CHK;
                ST_POLL_CHK: st <= busy ? ST_POLL_REQ : ret_st;
                ST_WT_OPEN: if (conn_on) st <= mode_sel ? ST_WT_CLOSE : ST_TX_TDL;
                ST_TX_TDL:  st <= ST_TX_PKL;
                ST_TX_PKL:  st <= ST_TX_SEND;
                ST_TX_SEND: begin
                    st     <= ST_POLL_REQ;
                    ret_st <= ST_TX_CLOSE;
                end
                ST_TX_CLOSE: begin
                    st     <= ST_POLL_REQ;
                    ret_st <= ST_WT_OPEN;
                end
                ST_WT_CLOSE: if (!conn_on) begin
                    st     <= ST_POLL_REQ;
                    ret_st <= ST_WT_OPEN;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign reg_addr    = bus.addr;
    assign reg_wr_en   = bus.en;
    assign reg_wr_data = bus.data;

    AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start_pulse) |=> (st == ST_PARAM && reg_wr_en)); // R2

    AST_RESET_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PARAM && idx == LAST_IDX) |=>
            (reg_wr_en && reg_addr == A_RST && reg_wr_data == 32'd0)); // R4

    AST_POLL_REPEATS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_POLL_CHK && busy) |=> (st == ST_POLL_REQ && !reg_wr_en)); // R5

    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (st == ST_POLL_CHK) |-> (reg_rd_data[31:1] == 31'd0)); // R5

    AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WT_OPEN && !conn_on) |=> (st == ST_WT_OPEN && !reg_wr_en)); // R6

    AST_RX_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WT_CLOSE && conn_on) |=> !reg_wr_en); // R10

    AST_CLOSE_AFTER_SEND: assert property (@(posedge clk) disable iff (rst)
        (st == ST_POLL_CHK && !busy && ret_st == ST_TX_CLOSE) |=>
            (reg_wr_en && reg_addr == A_CMD && reg_wr_data == CMD_CLOSE)); // R8

endmodule

// File: tb/toe_reg_sequencer_tb.sv
module toe_reg_sequencer_tb;
    localparam int DEB = 16;
    localparam logic [31:0] TLEN = 32'd23360;
    localparam logic [31:0] PLEN = 32'd1460;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_btn = 1'b0;
    logic        mode_sel = 1'b0;
    logic        conn_on = 1'b0;
    logic [31:0] reg_rd_data = 32'd0;
    logic [3:0]  reg_addr;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data;

    int n_vec = 0;
    int n_err = 0;
    int busy_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    toe_reg_sequencer #(.DEB_CYCLES(DEB), .TOTAL_LEN(TLEN), .PKT_LEN(PLEN),
                        .DST_PORT(16'd4000)) u_dut (
        .clk(clk), .rst(rst), .start_btn(start_btn), .mode_sel(mode_sel),
        .conn_on(conn_on), .reg_rd_data(reg_rd_data), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [36:0] act,
                       input logic [36:0] exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act={en,addr,data}=%h exp=%h", req, act, exp);
        end
    endtask

    // one clock: observe at the falling edge, then advance the engine model
    task automatic step();
        @(negedge clk);
        if (reg_wr_en) begin
            if (reg_addr == 4'd1 && reg_wr_data == 32'd0) busy_cnt = 9;
            if (reg_addr == 4'd1 && reg_wr_data == 32'd3) begin
                busy_cnt = 5;
                conn_on  = 1'b0;
            end
            if (reg_addr == 4'd0 && reg_wr_data == 32'd0) busy_cnt = 4;
        end else if (busy_cnt > 0) begin
            busy_cnt--;
        end
        reg_rd_data = {31'd0, busy_cnt > 0};
    endtask

    task automatic exp_quiet(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            step();
            chk(reg_wr_en == 1'b0, req, {reg_wr_en, reg_addr, reg_wr_data}, 37'd0);
        end
    endtask

    task automatic exp_wr(input logic [3:0] a, input logic [31:0] d, input string req);
        step();
        chk(reg_wr_en === 1'b1 && reg_addr === a && reg_wr_data === d, req,
            {reg_wr_en, reg_addr, reg_wr_data}, {1'b1, a, d});
    endtask

    task automatic exp_poll(input string req);
        bit b;
        int guard = 0;
        do begin
            step();
            chk(!reg_wr_en && reg_addr == 4'd1, req,
                {reg_wr_en, reg_addr, reg_wr_data}, {1'b0, 4'd1, 32'd0});
            step();
            chk(!reg_wr_en && reg_addr == 4'd1, req,
                {reg_wr_en, reg_addr, reg_wr_data}, {1'b0, 4'd1, 32'd0});
            b = reg_rd_data[0];
            guard++;
        end while (b && guard < 100);
    endtask

    task automatic tx_transfer();
        mode_sel = 1'b0;
        conn_on  = 1'b1;
        exp_wr(4'd2, TLEN, "R7 total length");
        exp_wr(4'd3, PLEN, "R7 packet length");
        exp_wr(4'd1, 32'd0, "R7 send command");
        exp_poll("R8 send poll");
        exp_wr(4'd1, 32'd3, "R8 active close");
        exp_poll("R9 close poll");
        exp_quiet(6, "R9 back to wait");
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            step();
            chk(reg_wr_en == 0 && reg_addr == 0 && reg_wr_data == 0, "R1 in reset",
                {reg_wr_en, reg_addr, reg_wr_data}, 37'd0);
        end
        rst = 1'b0;
        exp_quiet(5, "R1 idle after reset");

        // R2: short press is rejected
        start_btn = 1'b1;
        exp_quiet(DEB - 2, "R2 short press");
        start_btn = 1'b0;
        exp_quiet(DEB + 8, "R2 short press");

        // R2: accepted press, exact latency; held button
        start_btn = 1'b1;
        exp_quiet(DEB + 2, "R2 debounce latency");
        exp_wr(4'd0,  32'd1,        "R3 hold reset");
        exp_wr(4'd4,  32'h02030405, "R3 mac low");
        exp_wr(4'd5,  32'h00000001, "R3 mac high");
        exp_wr(4'd6,  32'hC0A80B2A, "R3 local ip");
        exp_wr(4'd7,  32'hC0A80B19, "R3 remote ip");
        exp_wr(4'd8,  32'h00000FA0, "R3 local port");
        exp_wr(4'd9,  32'h00000FA0, "R3 remote port");
        exp_wr(4'd10, 32'd0,        "R3 open mode");
        exp_wr(4'd0,  32'd0,        "R4 reset release");
        exp_poll("R5 init poll");
        exp_quiet(8, "R6 wait open, button held");
        start_btn = 1'b0;
        exp_quiet(DEB + 6, "R6 wait open");

        // R6: press while waiting is ignored
        start_btn = 1'b1;
        exp_quiet(DEB + 6, "R6 press ignored");
        start_btn = 1'b0;
        exp_quiet(DEB + 6, "R6 press ignored");

        // transmit transfer
        tx_transfer();

        // receive transfer, mode flips mid-transfer
        mode_sel = 1'b1;
        conn_on  = 1'b1;
        exp_quiet(5, "R10 receive silent");
        mode_sel = 1'b0;
        exp_quiet(5, "R12 mode change ignored");
        conn_on  = 1'b0;
        busy_cnt = 0;
        reg_rd_data = 32'd0;
        exp_poll("R10 close poll immediate");
        exp_quiet(6, "R10 back to wait");

        // second receive with busy after close
        mode_sel = 1'b1;
        conn_on  = 1'b1;
        exp_quiet(4, "R10 receive silent");
        conn_on  = 1'b0;
        busy_cnt = 3;
        reg_rd_data = 32'd1;
        exp_poll("R10 close poll busy");
        exp_quiet(4, "R10 back to wait");

        // R11: new transfer without reload
        tx_transfer();
        chk(n_vec > 12, "R11 transfer repeat", 37'(n_vec), 37'd12);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_err++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

endmodule